// File: doc/BRIEF.md
# Audio Descriptor Ring DMA Channel

This block is a bus-master DMA channel that feeds a single audio output stream. Software places up to 32 two-word buffer descriptors in memory, writes the ring's base address and a last-valid index, then sets the run bit. The engine reads each descriptor in turn and then reads that buffer's samples one word at a time into a one-word output slot. The link logic drains this slot one sample per pulse. When a buffer runs out, the engine moves to the next ring entry. It stops after the entry whose index equals the last-valid index. Software can then move that index forward to extend the stream without a restart.

If the link asks for a sample and the slot is empty, the block still supplies a fill value: either the last real sample or zero, as the current descriptor selects. If the engine is running at that moment, the event is recorded as a FIFO error. There are three sticky events: buffer done, last buffer done and FIFO error. Software clears each one by writing 1 to it. Each event drives the single interrupt line when its enable bit is set.

Top module: `audio_ring_dma`

## Requirements
- R1: The base register always reads with its three low bits at zero, whatever value was written to it.
- R2: The current, last-valid and prefetched indices are 5 bits wide, and arithmetic on them wraps modulo 32. Writes keep only the low 5 bits. After each descriptor load, the prefetched index equals the current index plus one.
- R3: Descriptor n is at base + 8*n. Its first word is the buffer's byte address. Its second word holds the sample count in bits 15:0, the done-request flag in bit 31 and the zero-fill flag in bit 30. Samples are read from consecutive 4-byte addresses and leave the output in memory order. A memory request is held, with a stable address, until its response arrives.
- R4: The count register (address 5) shows how many samples of the current buffer have not yet been read from memory.
- R5: When a buffer's last sample is read, status bit 3 is set only if that buffer's bit 31 flag is 1.
- R6: If the current index equals the last-valid index when a buffer's last sample is read, the engine sets status bit 2 and halts (status bit 0 = 1) with no further reads. If the run bit is set and the last-valid index is moved away, the engine advances to the next index and continues.
- R7: Status bit 1 reads 1 exactly when the current index equals the last-valid index.
- R8: A sample pulse that finds the slot empty outputs, on the next cycle, zero if the current descriptor's bit 30 is 1, or the last real sample if it is 0.
- R9: An empty-slot pulse sets sticky status bit 4 only while the engine is not halted.
- R10: Status bits 2, 3 and 4 are sticky. Writing 1 to one of these bits clears it. Writing 0 leaves it unchanged.
- R11: Clearing control bit 0 halts the engine at a sample boundary and keeps the index and count. Setting it again resumes with the next unread sample.
- R12: Writing control bit 1 while halted zeroes the current, prefetched and last-valid indices and the count, and clears the sticky bits. The write is ignored while the engine is running. Control bit 1 always reads 0.
- R13: irq = (bit3 and ctrl bit4) or (bit2 and ctrl bit2) or (bit4 and ctrl bit3).
- R14: After reset, status reads 0x03, the indices, count and control are zero, irq is low and the sample output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select: 0 base, 1 current, 2 last-valid, 3 prefetched, 4 status, 5 count, 6 control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory read request, held until response |
| mem_addr | output | 32 | Memory read byte address |
| mem_rvalid | input | 1 | Memory response strobe |
| mem_rdata | input | 32 | Memory response data |
| smp_take | input | 1 | Link pulls one sample |
| smp_data | output | 32 | Sample delivered for the last pull |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that memory sends exactly one response for each request while that request is held. They also assume that software rewrites neither the base register nor the descriptors while the engine is running, and that every descriptor count is nonzero. The bench's memory model answers a held request on the next cycle and lowers its response after one cycle. The bench writes descriptors and the base only while the channel is halted, and every count it uses is nonzero. Empty-slot pulls are made on purpose, both while running (back-to-back pulls) and while halted, so that both sides of the FIFO-error rule are exercised.

// File: rtl/adma_pkg.sv
// Shared encodings for the audio descriptor ring DMA channel.
// Assumes a 32-bit register port.
package adma_pkg;
    localparam int REG_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE, ST_DESC_A, ST_DESC_B, ST_SLOT, ST_DATA, ST_END
    } eng_state_t;

    localparam logic [2:0] RA_BASE  = 3'd0;
    localparam logic [2:0] RA_CUR   = 3'd1;
    localparam logic [2:0] RA_LAST  = 3'd2;
    localparam logic [2:0] RA_PREF  = 3'd3;
    localparam logic [2:0] RA_STAT  = 3'd4;
    localparam logic [2:0] RA_COUNT = 3'd5;
    localparam logic [2:0] RA_CTRL  = 3'd6;

    localparam int CB_RUN    = 0;
    localparam int CB_RST    = 1;
    localparam int CB_LASTIE = 2;
    localparam int CB_ERRIE  = 3;
    localparam int CB_DONEIE = 4;

    localparam int SB_HALT     = 0;
    localparam int SB_ATLAST   = 1;
    localparam int SB_LASTDONE = 2;
    localparam int SB_DONE     = 3;
    localparam int SB_ERR      = 4;

    localparam int DF_IRQ  = 31;
    localparam int DF_ZERO = 30;
endpackage

// File: rtl/adma_regs.sv
// Register file: base, last-valid index, control and sticky status.
// Assumes ev_* are single-cycle pulses from the engine and output slot.
module adma_regs
    import adma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 5,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [IDX_W-1:0]  civ,
    input  logic [IDX_W-1:0]  piv,
    input  logic [CNT_W-1:0]  count,
    input  logic              halted,
    input  logic              ev_done,
    input  logic              ev_lastdone,
    input  logic              ev_err,
    output logic [ADDR_W-1:0] base_addr,
    output logic [IDX_W-1:0]  lvi,
    output logic              run,
    output logic              rr_pulse,
    output logic              irq
);
    localparam int CTRL_W = 5;

    logic [ADDR_W-1:0] base_q;
    logic [IDX_W-1:0]  lvi_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic              lastdone_q, done_q, err_q;
    logic              stat_wr;
    logic [REG_W-1:0]  stat_w;

    assign stat_wr  = reg_we && (reg_addr == RA_STAT);
    assign rr_pulse = reg_we && (reg_addr == RA_CTRL) && reg_wdata[CB_RST] && halted;

    // Configuration registers: base, last-valid index, control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            lvi_q  <= '0;
            ctrl_q <= '0;
        end else begin
            if (reg_we && reg_addr == RA_BASE)
                base_q <= {reg_wdata[ADDR_W-1:3], 3'b000};
            if (rr_pulse)
                lvi_q <= '0;
            else if (reg_we && reg_addr == RA_LAST)
                lvi_q <= reg_wdata[IDX_W-1:0];
            if (reg_we && reg_addr == RA_CTRL)
                ctrl_q <= {reg_wdata[CB_DONEIE:CB_LASTIE], 1'b0, reg_wdata[CB_RUN]};
        end
    end

    // Sticky status: set by events (priority), cleared by writing 1.
    always_ff @(posedge clk) begin
        if (!rst_n || rr_pulse) begin
            lastdone_q <= 1'b0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            lastdone_q <= ev_lastdone | (lastdone_q & ~(stat_wr & reg_wdata[SB_LASTDONE]));
            done_q     <= ev_done     | (done_q     & ~(stat_wr & reg_wdata[SB_DONE]));
            err_q      <= ev_err      | (err_q      & ~(stat_wr & reg_wdata[SB_ERR]));
        end
    end

    assign stat_w = {{(REG_W-5){1'b0}}, err_q, done_q, lastdone_q, (civ == lvi_q), halted};

    // Read multiplexer.
    always_comb begin
        case (reg_addr)
            RA_BASE:  reg_rdata = REG_W'(base_q);
            RA_CUR:   reg_rdata = REG_W'(civ);
            RA_LAST:  reg_rdata = REG_W'(lvi_q);
            RA_PREF:  reg_rdata = REG_W'(piv);
            RA_STAT:  reg_rdata = stat_w;
            RA_COUNT: reg_rdata = REG_W'(count);
            RA_CTRL:  reg_rdata = REG_W'(ctrl_q);
            default:  reg_rdata = '0;
        endcase
    end

    assign base_addr = base_q;
    assign lvi       = lvi_q;
    assign run       = ctrl_q[CB_RUN];
    assign irq       = (done_q & ctrl_q[CB_DONEIE]) | (lastdone_q & ctrl_q[CB_LASTIE])
                     | (err_q & ctrl_q[CB_ERRIE]);

    // R9: an error event is visible as sticky status on the next cycle
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ev_err |=> err_q);
    // R10: writing 1 clears the done bit when no new event collides
    a_r10_w1c_done: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && reg_wdata[SB_DONE] && !ev_done) |=> !done_q);
endmodule

// File: rtl/adma_engine.sv
// Descriptor and sample fetch state machine with index and count tracking.
// Assumes one memory response per held request, nonzero descriptor counts,
// and no base or descriptor rewrite while running.
module adma_engine
    import adma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 5,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              rr_pulse,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [IDX_W-1:0]  lvi,
    input  logic              slot_full,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              push,
    output logic [DATA_W-1:0] push_data,
    output logic              zero_fill,
    output logic [IDX_W-1:0]  civ,
    output logic [IDX_W-1:0]  piv,
    output logic [CNT_W-1:0]  count,
    output logic              halted,
    output logic              ev_done,
    output logic              ev_lastdone
);
    localparam int DESC_SHIFT = 3;

    eng_state_t        st_q;
    logic [IDX_W-1:0]  civ_q, piv_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] ptr_q, desc_addr;
    logic              ioc_q, zf_q, last_smp;
    logic              desc_unused;

    assign desc_addr   = base_addr + ADDR_W'({civ_q, {DESC_SHIFT{1'b0}}});
    assign desc_unused = ^{mem_rdata[DF_ZERO-1:CNT_W], mem_rdata[1:0]};

    // Memory request and address follow the fetch state.
    always_comb begin
        mem_req = (st_q == ST_DESC_A) || (st_q == ST_DESC_B) || (st_q == ST_DATA);
        case (st_q)
            ST_DESC_A: mem_addr = desc_addr;
            ST_DESC_B: mem_addr = desc_addr + ADDR_W'(4);
            default:   mem_addr = ptr_q;
        endcase
    end

    assign push        = (st_q == ST_DATA) && mem_rvalid;
    assign push_data   = mem_rdata;
    assign last_smp    = push && (cnt_q == CNT_W'(1));
    assign ev_done     = last_smp && ioc_q;
    assign ev_lastdone = last_smp && (civ_q == lvi);
    assign halted      = (st_q == ST_IDLE) || (st_q == ST_END);

    // Fetch sequencing, index advance and per-buffer bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || rr_pulse) begin
            st_q  <= ST_IDLE;
            civ_q <= '0;
            piv_q <= '0;
            cnt_q <= '0;
            ptr_q <= '0;
            ioc_q <= 1'b0;
            zf_q  <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE:
                    if (run) st_q <= (cnt_q != '0) ? ST_SLOT : ST_DESC_A;
                ST_DESC_A:
                    if (mem_rvalid) begin
                        ptr_q <= {mem_rdata[ADDR_W-1:2], 2'b00};
                        st_q  <= ST_DESC_B;
                    end
                ST_DESC_B:
                    if (mem_rvalid) begin
                        cnt_q <= mem_rdata[CNT_W-1:0];
                        ioc_q <= mem_rdata[DF_IRQ];
                        zf_q  <= mem_rdata[DF_ZERO];
                        piv_q <= civ_q + IDX_W'(1);
                        st_q  <= ST_SLOT;
                    end
                ST_SLOT:
                    if (!run) st_q <= ST_IDLE;
                    else if (!slot_full) st_q <= ST_DATA;
                ST_DATA:
                    if (mem_rvalid) begin
                        ptr_q <= ptr_q + ADDR_W'(4);
                        cnt_q <= cnt_q - CNT_W'(1);
                        if (cnt_q == CNT_W'(1)) begin
                            if (civ_q == lvi) st_q <= ST_END;
                            else begin
                                civ_q <= civ_q + IDX_W'(1);
                                st_q  <= run ? ST_DESC_A : ST_IDLE;
                            end
                        end else begin
                            st_q <= ST_SLOT;
                        end
                    end
                ST_END:
                    if (run && civ_q != lvi) begin
                        civ_q <= civ_q + IDX_W'(1);
                        st_q  <= ST_DESC_A;
                    end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign zero_fill = zf_q;
    assign civ       = civ_q;
    assign piv       = piv_q;
    assign count     = cnt_q;

    // R3: an unanswered request stays up with the same address
    a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));
    // R6: completing the last valid buffer halts with no further reads
    a_r6_halt_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        ev_lastdone |=> (halted && !mem_req));
    // R11: with run low a halted engine stays halted
    a_r11_pause_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && halted) |=> halted);
endmodule

// File: rtl/adma_outslot.sv
// One-word output slot toward the link, with underrun fill policy.
// Assumes push only arrives while the slot is empty.
module adma_outslot #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              take,
    input  logic              zero_fill,
    output logic              full,
    output logic [DATA_W-1:0] smp_data,
    output logic              underrun
);
    logic              full_q;
    logic [DATA_W-1:0] hold_q, last_q, out_q;

    assign underrun = take && !full_q;

    // Slot fill/drain and output selection on each pull.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            hold_q <= '0;
            last_q <= '0;
            out_q  <= '0;
        end else begin
            if (take && full_q) begin
                out_q  <= hold_q;
                last_q <= hold_q;
            end else if (take) begin
                out_q <= zero_fill ? '0 : last_q;
            end
            if (push) begin
                hold_q <= push_data;
                full_q <= 1'b1;
            end else if (take) begin
                full_q <= 1'b0;
            end
        end
    end

    assign full     = full_q;
    assign smp_data = out_q;

    // R3: the engine never overwrites an unread sample
    a_r3_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full_q);
    // R8: zero-fill policy yields zero on an empty pull
    a_r8_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !full_q && zero_fill) |=> (smp_data == '0));
endmodule

// File: rtl/audio_ring_dma.sv
// Top of the audio descriptor ring DMA channel: registers, fetch engine
// and output slot. Assumes a single-outstanding memory read port.
module audio_ring_dma #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 5,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              smp_take,
    output logic [DATA_W-1:0] smp_data,
    output logic              irq
);
    logic [ADDR_W-1:0] base_addr;
    logic [IDX_W-1:0]  lvi, civ, piv;
    logic [CNT_W-1:0]  count;
    logic              run, rr_pulse, halted, ev_done, ev_lastdone, ev_err;
    logic              push, zero_fill, slot_full, underrun;
    logic [DATA_W-1:0] push_data;

    // Underrun only counts as an error while the engine runs.
    assign ev_err = underrun && !halted;

    adma_regs #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .civ(civ), .piv(piv),
        .count(count), .halted(halted), .ev_done(ev_done),
        .ev_lastdone(ev_lastdone), .ev_err(ev_err), .base_addr(base_addr),
        .lvi(lvi), .run(run), .rr_pulse(rr_pulse), .irq(irq)
    );

    adma_engine #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .run(run), .rr_pulse(rr_pulse),
        .base_addr(base_addr), .lvi(lvi), .slot_full(slot_full),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .push(push), .push_data(push_data),
        .zero_fill(zero_fill), .civ(civ), .piv(piv), .count(count),
        .halted(halted), .ev_done(ev_done), .ev_lastdone(ev_lastdone)
    );

    adma_outslot #(.DATA_W(DATA_W)) u_slot (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
        .take(smp_take), .zero_fill(zero_fill), .full(slot_full),
        .smp_data(smp_data), .underrun(underrun)
    );
endmodule

// File: tb/audio_ring_dma_test.sv
`timescale 1ns/100ps
module audio_ring_dma_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        mem_req, mem_rvalid;
    logic [31:0] mem_addr, mem_rdata;
    logic        smp_take;
    logic [31:0] smp_data;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] mem [0:255];

    always #2.5 clk = ~clk;

    audio_ring_dma uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .smp_take(smp_take), .smp_data(smp_data), .irq(irq)
    );

    typedef struct packed {
        logic [31:0] data;
        logic [15:0] cnt;
        logic [4:0]  idx;
    } step_t;

    // Expected sample, remaining count and current index right after each pull.
    localparam step_t STEPS [5] = '{
        '{32'h5A00_0080, 16'd2, 5'd0},
        '{32'h5A00_0081, 16'd1, 5'd0},
        '{32'h5A00_0082, 16'd2, 5'd1},
        '{32'h5A00_00A0, 16'd1, 5'd1},
        '{32'h5A00_00A1, 16'd0, 5'd1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #0.5;
        v = reg_rdata;
    endtask

    task automatic pull(output logic [31:0] v);
        @(negedge clk);
        smp_take = 1'b1;
        @(negedge clk);
        smp_take = 1'b0;
        v = smp_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Memory model: answers a held request on the following edge.
    initial begin
        mem_rvalid = 1'b0;
        mem_rdata  = '0;
        forever begin
            @(negedge clk);
            if (mem_rvalid) mem_rvalid = 1'b0;
            else if (mem_req) begin
                mem_rvalid = 1'b1;
                mem_rdata  = mem[mem_addr[9:2]];
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R14 watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v, v2;
        for (int i = 0; i < 256; i++) mem[i] = 32'h5A00_0000 + i;
        mem[64] = 32'h0000_0200; mem[65] = 32'h8000_0003;
        mem[66] = 32'h0000_0280; mem[67] = 32'h4000_0002;
        mem[68] = 32'h0000_0300; mem[69] = 32'h0000_0001;
        mem[70] = 32'h0000_0380; mem[71] = 32'h0000_0004;
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; smp_take = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R14 reset state
        rd(3'd4, v); chk("R14 status", v, 32'h03);
        rd(3'd1, v); chk("R14 civ", v, 0);
        rd(3'd5, v); chk("R14 count", v, 0);
        rd(3'd6, v); chk("R14 ctrl", v, 0);
        chk("R14 irq", {31'b0, irq}, 0);
        chk("R14 smp_data", smp_data, 0);

        // R1 base alignment, R2 index width
        wr(3'd0, 32'h0000_0107);
        rd(3'd0, v); chk("R1 base low bits", v, 32'h100);
        wr(3'd2, 32'h25);
        rd(3'd2, v); chk("R2 lvi masked", v, 32'h05);
        wr(3'd2, 32'h01);
        rd(3'd4, v); chk("R7 civ!=lvi", v, 32'h01);

        // Main stream: table walk (R3, R4)
        wr(3'd6, 32'h1D);
        for (int i = 0; i < 5; i++) begin
            idle(12);
            pull(v);
            chk("R3 sample order", v, STEPS[i].data);
            rd(3'd5, v); chk("R4 count", v, 32'(STEPS[i].cnt));
            rd(3'd1, v); chk("R2 civ", v, 32'(STEPS[i].idx));
        end
        idle(5);
        rd(3'd4, v); chk("R6 R5 R7 status after last", v, 32'h0F);
        rd(3'd3, v); chk("R2 piv", v, 32'h02);
        chk("R13 irq", {31'b0, irq}, 1);

        // R8 zero fill while halted, R9 no error while halted
        pull(v); chk("R8 zero fill", v, 0);
        rd(3'd4, v); chk("R9 no error when halted", v, 32'h0F);

        // R10 write-one-to-clear
        wr(3'd4, 32'h08);
        rd(3'd4, v); chk("R10 clear done", v, 32'h07);
        wr(3'd4, 32'h00);
        rd(3'd4, v); chk("R10 zero write", v, 32'h07);
        chk("R13 irq lastdone", {31'b0, irq}, 1);
        wr(3'd4, 32'h04);
        rd(3'd4, v); chk("R10 clear lastdone", v, 32'h03);
        chk("R13 irq low", {31'b0, irq}, 0);

        // R6 restart by moving the last-valid index
        wr(3'd2, 32'h02);
        idle(12);
        pull(v); chk("R6 resume sample", v, 32'h5A00_00C0);
        idle(3);
        rd(3'd4, v); chk("R5 no done without flag", v, 32'h07);
        wr(3'd4, 32'h04);
        pull(v); chk("R8 repeat last", v, 32'h5A00_00C0);

        // R11 pause and resume
        wr(3'd2, 32'h03);
        idle(12);
        wr(3'd6, 32'h1C);
        idle(3);
        rd(3'd4, v); chk("R11 paused status", v, 32'h03);
        rd(3'd5, v); chk("R11 count kept", v, 32'h03);
        pull(v); chk("R11 held sample", v, 32'h5A00_00E0);
        pull(v); chk("R9 paused underrun repeat", v, 32'h5A00_00E0);
        rd(3'd4, v); chk("R9 paused no error", v, 32'h03);
        wr(3'd6, 32'h1D);
        idle(12);

        // R9 back-to-back pulls while running
        @(negedge clk); smp_take = 1'b1;
        @(negedge clk); v = smp_data;
        @(negedge clk); smp_take = 1'b0; v2 = smp_data;
        chk("R11 resumed sample", v, 32'h5A00_00E1);
        chk("R8 running repeat", v2, 32'h5A00_00E1);
        rd(3'd4, v); chk("R9 running error", v & 32'h11, 32'h10);
        chk("R13 irq error", {31'b0, irq}, 1);

        // R12 ignored while running, self-clearing
        idle(4);
        wr(3'd6, 32'h1F);
        rd(3'd1, v); chk("R12 ignored when running", v, 32'h03);
        rd(3'd6, v); chk("R12 self clear", v, 32'h1D);
        wr(3'd4, 32'h10);
        idle(12); pull(v); chk("R3 sample E2", v, 32'h5A00_00E2);
        idle(12); pull(v); chk("R3 sample E3", v, 32'h5A00_00E3);
        idle(5);
        rd(3'd4, v); chk("R6 halted at end", v, 32'h07);

        // R12 reset registers while halted
        wr(3'd6, 32'h02);
        rd(3'd1, v); chk("R12 civ", v, 0);
        rd(3'd2, v); chk("R12 lvi", v, 0);
        rd(3'd3, v); chk("R12 piv", v, 0);
        rd(3'd5, v); chk("R12 count", v, 0);
        rd(3'd4, v); chk("R12 status", v, 32'h03);
        rd(3'd6, v); chk("R12 ctrl", v, 0);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule